// File: doc/BRIEF.md
# FIFO DMA Request Generator

This block turns the fill levels of one receive FIFO and one transmit FIFO into handshake requests for a DMA controller. On the receive side it raises a burst request when at least one full burst is waiting. It raises a single request when some words are waiting but fewer than a burst. After a receive timeout it switches to dedicated "last" requests, so the controller can drain the remainder and move to its next descriptor. If the timeout fires while the receive FIFO is empty, no DMA request is raised. A sticky interrupt is raised instead.

On the transmit side only a burst request exists. It is raised when the FIFO has room for a whole burst. A compact-mode input restricts all requests to even word counts. A clear input per direction, pulsed by the controller after each transfer, forces a one-cycle gap in that direction's requests. All requests are registered, so they follow the inputs of the previous clock edge.

Top module: `dma_req_gen`

## Requirements
- R1: When the receive level was at least BURST (default 4) on the previous edge, with no last-request case and no clear, `rx_breq_o` is high and `rx_sreq_o` is low.
- R2: When the receive level was between 1 and BURST-1 on the previous edge, with no last-request case and no clear, `rx_sreq_o` is high and `rx_breq_o` is low. A level of 0 raises no receive request.
- R3: In the cycle after `rx_clr_i` is sampled high, all four receive requests are low. In the cycle after `tx_clr_i` is sampled high, `tx_breq_o` is low. Requests return on the following cycle if the level still calls for them.
- R4: While a timeout is pending and the receive level equals BURST, `rx_lbreq_o` is high and both normal receive requests are low.
- R5: While a timeout is pending and the receive level equals one unit (1 word, or 2 words in compact mode), `rx_lsreq_o` is high and both normal receive requests are low.
- R6: The last requests are never high together with each other or with a normal receive request.
- R7: A timeout pulse sampled with a non-zero receive level sets the pending state. The pending state is kept until the receive level is 0 or reset. At other levels the normal requests continue while the state is pending.
- R8: A timeout pulse sampled with a receive level of 0 raises no DMA request. It sets `rx_toe_irq_o` on the next cycle. The interrupt stays high until `irq_clr_i` is sampled high, and a new timeout on empty wins over a clear in the same cycle.
- R9: With `compact_i` high, an odd level raises no request in that direction. The receive single request then appears at a level of 2.
- R10: `tx_breq_o` is high when DEPTH minus the transmit level is at least BURST. There is no transmit single request.
- R11: While `rst_ni` is low, every output is low and the pending and interrupt state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| compact_i | input | 1 | Compact mode: requests only at even levels |
| rx_level_i | input | $clog2(DEPTH)+1 | Words held in the receive FIFO |
| tx_level_i | input | $clog2(DEPTH)+1 | Words held in the transmit FIFO |
| rx_timeout_i | input | 1 | Receive timeout pulse |
| rx_clr_i | input | 1 | Receive transfer-complete clear from the DMA controller |
| tx_clr_i | input | 1 | Transmit transfer-complete clear from the DMA controller |
| irq_clr_i | input | 1 | Clears the timeout-on-empty interrupt |
| rx_breq_o | output | 1 | Receive burst request |
| rx_sreq_o | output | 1 | Receive single request |
| rx_lbreq_o | output | 1 | Receive last-burst request |
| rx_lsreq_o | output | 1 | Receive last-single request |
| rx_toe_irq_o | output | 1 | Timeout-on-empty interrupt |
| tx_breq_o | output | 1 | Transmit burst request |

## Verification
The receive level is swept across 0, 1, 3, the exact burst size and values above it. This separates the burst and single thresholds from each other and from the idle case. The same levels are repeated after a timeout, which shows that only the exact burst and unit levels switch to the last requests and that the pending state survives partial drains until the FIFO is empty. Compact mode is tried with odd and even levels on both directions to expose any parity gating error. Clear pulses and timeouts on an empty FIFO check the one-cycle request gap and the sticky interrupt with its clear.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  typedef struct packed {
    logic breq;
    logic sreq;
    logic lbreq;
    logic lsreq;
  } rx_req_t;
endpackage

// File: rtl/req_gap.sv
// Registers raw requests; a clear sampled high forces one low cycle.
module req_gap #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    req_o <= '0;
    else if (clr_i) req_o <= '0;
    else            req_o <= raw_i;
  end
endmodule

// File: rtl/rx_req_unit.sv
module rx_req_unit
  import dma_req_pkg::*;
#(
  parameter int BURST = 4,
  parameter int LW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          compact_i,
  input  logic [LW-1:0] level_i,
  input  logic          timeout_i,
  input  logic          irq_clr_i,
  output rx_req_t       raw_o,
  output logic          toe_irq_o
);
  localparam logic [LW-1:0] BURST_L = LW'(BURST);

  logic          pend_q, pend_d, irq_d;
  logic          empty, parity_ok, has, last_b, last_s;
  logic [LW-1:0] unit;

  assign empty     = (level_i == '0);
  assign unit      = compact_i ? LW'(2) : LW'(1);
  assign parity_ok = !compact_i || !level_i[0];
  assign has       = !empty && parity_ok;

  // next-state pending so the registered request reflects this edge's timeout
  always_comb begin
    if (empty)          pend_d = 1'b0;
    else if (timeout_i) pend_d = 1'b1;
    else                pend_d = pend_q;
  end

  always_comb begin
    if (timeout_i && empty) irq_d = 1'b1;
    else if (irq_clr_i)     irq_d = 1'b0;
    else                    irq_d = toe_irq_o;
  end

  assign last_b = pend_d && (level_i == BURST_L);
  assign last_s = pend_d && (level_i == unit) && !last_b;

  always_comb begin
    raw_o.lbreq = has && last_b;
    raw_o.lsreq = has && last_s;
    raw_o.breq  = has && !last_b && !last_s && (level_i >= BURST_L);
    raw_o.sreq  = has && !last_b && !last_s && (level_i <  BURST_L);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      toe_irq_o <= 1'b0;
    end else begin
      pend_q    <= pend_d;
      toe_irq_o <= irq_d;
    end
  end
endmodule

// File: rtl/tx_req_unit.sv
module tx_req_unit #(
  parameter int BURST = 4,
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input  logic          compact_i,
  input  logic [LW-1:0] level_i,
  output logic          raw_o
);
  localparam logic [LW-1:0] BURST_L = LW'(BURST);
  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

  logic [LW-1:0] space;
  assign space = DEPTH_L - level_i;
  assign raw_o = (space >= BURST_L) && (!compact_i || !level_i[0]);
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
  import dma_req_pkg::*;
#(
  parameter int BURST = 4,
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          compact_i,
  input  logic [LW-1:0] rx_level_i,
  input  logic [LW-1:0] tx_level_i,
  input  logic          rx_timeout_i,
  input  logic          rx_clr_i,
  input  logic          tx_clr_i,
  input  logic          irq_clr_i,
  output logic          rx_breq_o,
  output logic          rx_sreq_o,
  output logic          rx_lbreq_o,
  output logic          rx_lsreq_o,
  output logic          rx_toe_irq_o,
  output logic          tx_breq_o
);
  rx_req_t rx_raw, rx_req;
  logic    tx_raw;

  rx_req_unit #(.BURST(BURST), .LW(LW)) rx_u (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .compact_i (compact_i),
    .level_i   (rx_level_i),
    .timeout_i (rx_timeout_i),
    .irq_clr_i (irq_clr_i),
    .raw_o     (rx_raw),
    .toe_irq_o (rx_toe_irq_o)
  );

  tx_req_unit #(.BURST(BURST), .DEPTH(DEPTH), .LW(LW)) tx_u (
    .compact_i (compact_i),
    .level_i   (tx_level_i),
    .raw_o     (tx_raw)
  );

  req_gap #(.W($bits(rx_req_t))) rx_gap_u (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rx_clr_i),
    .raw_i  (rx_raw),
    .req_o  (rx_req)
  );

  req_gap #(.W(1)) tx_gap_u (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tx_clr_i),
    .raw_i  (tx_raw),
    .req_o  (tx_breq_o)
  );

  assign rx_breq_o  = rx_req.breq;
  assign rx_sreq_o  = rx_req.sreq;
  assign rx_lbreq_o = rx_req.lbreq;
  assign rx_lsreq_o = rx_req.lsreq;
endmodule

// File: rtl/dma_req_gen_chk.sv
module dma_req_gen_chk #(
  parameter int BURST = 4,
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          compact_i,
  input logic [LW-1:0] rx_level_i,
  input logic [LW-1:0] tx_level_i,
  input logic          rx_timeout_i,
  input logic          rx_clr_i,
  input logic          tx_clr_i,
  input logic          irq_clr_i,
  input logic          rx_breq_o,
  input logic          rx_sreq_o,
  input logic          rx_lbreq_o,
  input logic          rx_lsreq_o,
  input logic          rx_toe_irq_o,
  input logic          tx_breq_o
);
  logic rx_any;
  assign rx_any = rx_breq_o | rx_sreq_o | rx_lbreq_o | rx_lsreq_o;

  assert_rx_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_clr_i |=> !rx_any);

  assert_tx_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_clr_i |=> !tx_breq_o);

  assert_last_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({rx_lbreq_o, rx_lsreq_o}) <= 1 &&
    (!(rx_lbreq_o || rx_lsreq_o) || !(rx_breq_o || rx_sreq_o)));

  assert_toe_noreq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_timeout_i && rx_level_i == '0) |=> (rx_toe_irq_o && !rx_any));

  assert_irq_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_toe_irq_o && !irq_clr_i) |=> rx_toe_irq_o);

  assert_rx_odd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (compact_i && rx_level_i[0]) |=> !rx_any);

  assert_tx_odd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (compact_i && tx_level_i[0]) |=> !tx_breq_o);

  assert_tx_space_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_clr_i && !compact_i && int'(tx_level_i) <= DEPTH - BURST) |=> tx_breq_o);
endmodule

bind dma_req_gen dma_req_gen_chk #(.BURST(BURST), .DEPTH(DEPTH), .LW(LW)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .compact_i    (compact_i),
  .rx_level_i   (rx_level_i),
  .tx_level_i   (tx_level_i),
  .rx_timeout_i (rx_timeout_i),
  .rx_clr_i     (rx_clr_i),
  .tx_clr_i     (tx_clr_i),
  .irq_clr_i    (irq_clr_i),
  .rx_breq_o    (rx_breq_o),
  .rx_sreq_o    (rx_sreq_o),
  .rx_lbreq_o   (rx_lbreq_o),
  .rx_lsreq_o   (rx_lsreq_o),
  .rx_toe_irq_o (rx_toe_irq_o),
  .tx_breq_o    (tx_breq_o)
);

// File: tb/dma_req_gen_tb_top.sv
module dma_req_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BURST = 4;
  localparam int DEPTH = 8;
  localparam int LW    = $clog2(DEPTH) + 1;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          compact = 1'b0;
  logic [LW-1:0] rx_level = '0;
  logic [LW-1:0] tx_level = LW'(DEPTH);
  logic          rx_timeout = 1'b0, rx_clr = 1'b0, tx_clr = 1'b0, irq_clr = 1'b0;
  logic          rx_breq, rx_sreq, rx_lbreq, rx_lsreq, rx_toe_irq, tx_breq;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_req_gen #(.BURST(BURST), .DEPTH(DEPTH)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .compact_i    (compact),
    .rx_level_i   (rx_level),
    .tx_level_i   (tx_level),
    .rx_timeout_i (rx_timeout),
    .rx_clr_i     (rx_clr),
    .tx_clr_i     (tx_clr),
    .irq_clr_i    (irq_clr),
    .rx_breq_o    (rx_breq),
    .rx_sreq_o    (rx_sreq),
    .rx_lbreq_o   (rx_lbreq),
    .rx_lsreq_o   (rx_lsreq),
    .rx_toe_irq_o (rx_toe_irq),
    .tx_breq_o    (tx_breq)
  );

  // expected vector order: {breq, sreq, lbreq, lsreq, toe_irq, tx_breq}
  task automatic chk(input string tag, input logic [5:0] exp);
    logic [5:0] act;
    act = {rx_breq, rx_sreq, rx_lbreq, rx_lsreq, rx_toe_irq, tx_breq};
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic rx_at(input int lvl);
    rx_level = LW'(lvl);
    step();
  endtask

  task automatic pulse_timeout();
    rx_timeout = 1'b1;
    step();
    rx_timeout = 1'b0;
  endtask

  task automatic t_reset();
    step();
    chk("R11 reset", 6'b000000);
    rst_ni = 1'b1;
    step();
    chk("R11 after release", 6'b000000);
  endtask

  task automatic t_rx_normal();
    rx_at(5); chk("R1 level5", 6'b100000);
    rx_at(4); chk("R1 level4", 6'b100000);
    rx_at(8); chk("R1 level8", 6'b100000);
    rx_at(3); chk("R2 level3", 6'b010000);
    rx_at(1); chk("R2 level1", 6'b010000);
    rx_at(0); chk("R2 level0", 6'b000000);
  endtask

  task automatic t_clear_gap();
    rx_at(6); chk("R3 pre", 6'b100000);
    rx_clr = 1'b1; step(); rx_clr = 1'b0;
    chk("R3 rx gap", 6'b000000);
    step(); chk("R3 rx resume", 6'b100000);
    tx_level = '0; step(); chk("R3 tx pre", 6'b100001);
    tx_clr = 1'b1; step(); tx_clr = 1'b0;
    chk("R3 tx gap", 6'b100000);
    step(); chk("R3 tx resume", 6'b100001);
    tx_level = LW'(DEPTH); rx_at(0); chk("R3 idle", 6'b000000);
  endtask

  task automatic t_timeout_last();
    rx_at(4);
    pulse_timeout(); chk("R4 last burst", 6'b001000);
    rx_at(3); chk("R7 pending normal", 6'b010000);
    rx_at(1); chk("R5 last single", 6'b000100);
    rx_at(0); chk("R7 empty", 6'b000000);
    rx_at(4); chk("R7 pending cleared", 6'b100000);
    pulse_timeout(); chk("R6 last only", 6'b001000);
    rx_at(6); chk("R7 pending above burst", 6'b100000);
    rx_at(0);
  endtask

  task automatic t_toe();
    pulse_timeout(); chk("R8 toe raise", 6'b000010);
    step(); step(); chk("R8 toe sticky", 6'b000010);
    rx_at(4); chk("R8 no pending from empty", 6'b100010);
    rx_at(0);
    irq_clr = 1'b1; step(); irq_clr = 1'b0;
    chk("R8 toe cleared", 6'b000000);
    pulse_timeout(); step();
    rx_timeout = 1'b1; irq_clr = 1'b1; step();
    rx_timeout = 1'b0; irq_clr = 1'b0;
    chk("R8 set wins", 6'b000010);
    irq_clr = 1'b1; step(); irq_clr = 1'b0;
    chk("R8 final clear", 6'b000000);
  endtask

  task automatic t_compact();
    compact = 1'b1;
    rx_at(3); chk("R9 odd rx", 6'b000000);
    rx_at(2); chk("R9 single at two", 6'b010000);
    rx_at(4); chk("R9 even burst", 6'b100000);
    pulse_timeout(); chk("R9 compact last burst", 6'b001000);
    rx_at(3); chk("R9 pending odd", 6'b000000);
    rx_at(2); chk("R5 compact last single", 6'b000100);
    rx_at(0);
    tx_level = LW'(3); step(); chk("R9 odd tx", 6'b000000);
    tx_level = LW'(2); step(); chk("R9 even tx", 6'b000001);
    compact = 1'b0; tx_level = LW'(DEPTH); step();
  endtask

  task automatic t_tx();
    tx_level = LW'(4); step(); chk("R10 space4", 6'b000001);
    tx_level = LW'(5); step(); chk("R10 space3", 6'b000000);
    tx_level = LW'(1); step(); chk("R10 space7", 6'b000001);
    tx_level = LW'(0); step(); chk("R10 empty", 6'b000001);
    tx_level = LW'(8); step(); chk("R10 full", 6'b000000);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    t_reset();
    t_rx_normal();
    t_clear_gap();
    t_timeout_last();
    t_toe();
    t_compact();
    t_tx();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_err++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    finish_run();
  end
endmodule